// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM arriving on a three-wire serial port (bit clock, channel clock, serial data) and turns it into parallel left and right samples. All three port lines are oversampled in the system clock domain. Data and channel-clock levels are taken on each rising edge of the bit clock. A change in the channel-clock level marks the end of one word and the start of the next. Every sample comes out as a 20-bit two's-complement value, with shorter words placed in the upper bits.

Two static control inputs set the word format. A 2-bit width code selects right-justified 16, 18 or 20-bit data, or a delayed-start format that carries up to 20 bits. A 2-bit frame mode selects 32, 48 or 64 bit clocks per sample period, or a free-running 64fs-style mode that accepts a range of period lengths. A polarity input decides which channel-clock level carries the left channel. The block checks each completed word against the selected format. A word that does not fit sets a sticky error flag, and the stereo pair it belongs to is not delivered. A good pair is presented on both outputs together, with a one-cycle strobe.

Top module: `sar_rx`

## Requirements
- R1: While reset is asserted, both sample outputs are zero and the valid strobe and the error flag are low.
- R2: With width code 00, 01 or 10, the sample is the last 16, 18 or 20 bits (respectively) received before the channel-clock change that ends the word, MSB first. Data is sampled on rising bit-clock edges.
- R3: A right-justified sample shorter than 20 bits is placed in the top bits of the 20-bit output, and its unused low bits are zero.
- R4: With width code 11, the bit taken on the first rising edge after a channel-clock change is skipped. The next 20 bits fill the output from bit 19 down to bit 0.
- R5: When the polarity input is 1, a word sent while the channel clock is high is the left sample. When it is 0, a word sent while the channel clock is low is the left sample.
- R6: A left word followed by a right word gives one pulse on the valid strobe, one cycle wide. The pulse comes 5 clock cycles after the rising bit-clock edge that ends the right word. Both outputs change only in that cycle and hold their values at all other times.
- R7: Frame mode 01 accepts exactly 16 bits per channel, mode 10 exactly 24, and mode 11 exactly 32. Any other word length is a format error.
- R8: In frame mode 00, a word is accepted if its length is between the data width and 64 bits. With width code 11, the length must be exactly 32.
- R9: Frame mode 01 with a width code other than 00, and frame mode 10 with width code 11, are illegal. Every word completed under such a setting is a format error, and no valid strobe is produced.
- R10: A format error sets the error flag 5 cycles after the ending edge of the bad word. The flag stays set until reset. A bad word cancels any pending left sample, so its pair is not delivered.
- R11: The partial word received before the first channel-clock change after reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Channel clock |
| sdata_i | input | 1 | Serial data, MSB first |
| width_sel_i | input | 2 | Width code: 00=16, 01=18, 10=20, 11=delayed-start up to 20 |
| frame_mode_i | input | 2 | 00=free-running, 01=32, 10=48, 11=64 bit clocks per frame |
| left_high_i | input | 1 | 1: channel clock high carries the left channel |
| left_o | output | 20 | Left sample |
| right_o | output | 20 | Right sample |
| pair_valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| fmt_err_o | output | 1 | Sticky format error flag |

## Verification
Both the valid strobe and the error flag are due exactly 5 cycles after the rising bit-clock edge that ends a word: two synchronizer stages, the framer, the word assembler and the output register. The bench drives each rising bit-clock edge just after a clock edge and notes the cycle number. Its behavioural model then files any pair or error under that cycle plus 5. On every cycle it compares the strobe, the flag and, when the strobe is due, both samples. A result that arrives one cycle early or one cycle late is therefore reported as a mismatch.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SAMPLE_W    = 20;
    localparam int CNT_W       = 7;
    localparam int POS_W       = $clog2(SAMPLE_W);
    localparam int MAX_FREE    = 64;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_32   = 2'b01,
        MODE_48   = 2'b10,
        MODE_64   = 2'b11
    } frame_mode_e;

    typedef enum logic [1:0] {
        WID_16  = 2'b00,
        WID_18  = 2'b01,
        WID_20  = 2'b10,
        WID_DLY = 2'b11
    } width_e;

    function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] w);
        case (w)
            WID_16:  return CNT_W'(16);
            WID_18:  return CNT_W'(18);
            default: return CNT_W'(20);
        endcase
    endfunction

    function automatic logic combo_ok(input logic [1:0] mode, input logic [1:0] w);
        case (mode)
            MODE_32: return (w == WID_16);
            MODE_48: return (w != WID_DLY);
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic len_ok(input logic [1:0] mode, input logic [1:0] w,
                                    input logic [CNT_W-1:0] len);
        case (mode)
            MODE_32: return (len == CNT_W'(16));
            MODE_48: return (len == CNT_W'(24));
            MODE_64: return (len == CNT_W'(32));
            default: begin
                if (w == WID_DLY) return (len == CNT_W'(32));
                return (len >= word_bits(w)) && (len <= CNT_W'(MAX_FREE));
            end
        endcase
    endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sar_framer.sv
module sar_framer
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_s,
    input  logic             lrclk_s,
    input  logic             sdata_s,
    output logic             bit_stb_o,
    output logic             bit_val_o,
    output logic [CNT_W-1:0] bit_idx_o,
    output logic             wend_o,
    output logic [CNT_W-1:0] wlen_o,
    output logic             wchan_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             prev_bclk;
        logic             have;
        logic             started;
        logic             lr;
        logic [CNT_W-1:0] cnt;
        logic             bit_stb;
        logic             bit_val;
        logic [CNT_W-1:0] bit_idx;
        logic             wend;
        logic [CNT_W-1:0] wlen;
        logic             wchan;
    } framer_t;

    framer_t st_d, st_q;
    logic    rise;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        rise    = bclk_s & ~st_q.prev_bclk;
        cnt_inc = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + 1'b1;
        st_d           = st_q;
        st_d.prev_bclk = bclk_s;
        st_d.bit_stb   = 1'b0;
        st_d.wend      = 1'b0;
        if (rise) begin
            st_d.bit_stb = 1'b1;
            st_d.bit_val = sdata_s;
            if (!st_q.have) begin
                st_d.have = 1'b1;
                st_d.lr   = lrclk_s;
                st_d.cnt  = '0;
            end else if (lrclk_s != st_q.lr) begin
                st_d.wend    = st_q.started;
                st_d.wlen    = cnt_inc;
                st_d.wchan   = st_q.lr;
                st_d.started = 1'b1;
                st_d.lr      = lrclk_s;
                st_d.cnt     = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
            st_d.bit_idx = st_d.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_stb_o = st_q.bit_stb;
    assign bit_val_o = st_q.bit_val;
    assign bit_idx_o = st_q.bit_idx;
    assign wend_o    = st_q.wend;
    assign wlen_o    = st_q.wlen;
    assign wchan_o   = st_q.wchan;

endmodule

// File: rtl/sar_word.sv
module sar_word
    import sar_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          width_sel_i,
    input  logic                bit_stb_i,
    input  logic                bit_val_i,
    input  logic [CNT_W-1:0]    bit_idx_i,
    input  logic                wend_i,
    input  logic [CNT_W-1:0]    wlen_i,
    input  logic                wchan_i,
    output logic                word_stb_o,
    output logic [SAMPLE_W-1:0] word_o,
    output logic [CNT_W-1:0]    word_len_o,
    output logic                word_chan_o
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] shreg;
        logic [SAMPLE_W-1:0] dly;
        logic                stb;
        logic [SAMPLE_W-1:0] word;
        logic [CNT_W-1:0]    len;
        logic                chan;
    } word_t;

    word_t st_d, st_q;
    logic [SAMPLE_W-1:0] rj_word;
    logic [POS_W-1:0]    pos;

    always_comb begin
        rj_word = st_q.shreg << (SAMPLE_W - int'(word_bits(width_sel_i)));
        pos     = POS_W'(SAMPLE_W - int'(bit_idx_i));
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (bit_stb_i) begin
            if (wend_i) begin
                st_d.stb  = 1'b1;
                st_d.word = (width_sel_i == WID_DLY) ? st_q.dly : rj_word;
                st_d.len  = wlen_i;
                st_d.chan = wchan_i;
            end
            st_d.shreg = {st_q.shreg[SAMPLE_W-2:0], bit_val_i};
            if (bit_idx_i == '0) begin
                st_d.dly = '0;
            end else if (bit_idx_i <= CNT_W'(SAMPLE_W)) begin
                st_d.dly[pos] = bit_val_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_stb_o  = st_q.stb;
    assign word_o      = st_q.word;
    assign word_len_o  = st_q.len;
    assign word_chan_o = st_q.chan;

endmodule

// File: rtl/sar_rx.sv
module sar_rx
    import sar_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                lrclk_i,
    input  logic                sdata_i,
    input  logic [1:0]          width_sel_i,
    input  logic [1:0]          frame_mode_i,
    input  logic                left_high_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                pair_valid_o,
    output logic                fmt_err_o
);

    logic [2:0]          sync_w;
    logic                bit_stb, bit_val, wend, wchan;
    logic [CNT_W-1:0]    bit_idx, wlen;
    logic                word_stb, word_chan;
    logic [SAMPLE_W-1:0] word;
    logic [CNT_W-1:0]    word_len;

    sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bclk_i, lrclk_i, sdata_i}),
        .sync_o  (sync_w)
    );

    sar_framer framer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_s    (sync_w[2]),
        .lrclk_s   (sync_w[1]),
        .sdata_s   (sync_w[0]),
        .bit_stb_o (bit_stb),
        .bit_val_o (bit_val),
        .bit_idx_o (bit_idx),
        .wend_o    (wend),
        .wlen_o    (wlen),
        .wchan_o   (wchan)
    );

    sar_word word_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .width_sel_i (width_sel_i),
        .bit_stb_i   (bit_stb),
        .bit_val_i   (bit_val),
        .bit_idx_i   (bit_idx),
        .wend_i      (wend),
        .wlen_i      (wlen),
        .wchan_i     (wchan),
        .word_stb_o  (word_stb),
        .word_o      (word),
        .word_len_o  (word_len),
        .word_chan_o (word_chan)
    );

    typedef struct packed {
        logic [SAMPLE_W-1:0] left_hold;
        logic                left_ok;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
        logic                err;
    } out_t;

    out_t st_d, st_q;
    logic good, is_left;

    always_comb begin
        good     = combo_ok(frame_mode_i, width_sel_i) &&
                   len_ok(frame_mode_i, width_sel_i, word_len);
        is_left  = (word_chan == left_high_i);
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (word_stb) begin
            if (!good) begin
                st_d.err     = 1'b1;
                st_d.left_ok = 1'b0;
            end else if (is_left) begin
                st_d.left_hold = word;
                st_d.left_ok   = 1'b1;
            end else if (st_q.left_ok) begin
                st_d.left    = st_q.left_hold;
                st_d.right   = word;
                st_d.valid   = 1'b1;
                st_d.left_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o       = st_q.left;
    assign right_o      = st_q.right;
    assign pair_valid_o = st_q.valid;
    assign fmt_err_o    = st_q.err;

endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk
    import sar_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          width_sel_i,
    input logic [1:0]          frame_mode_i,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                pair_valid_o,
    input logic                fmt_err_o
);

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |=> !pair_valid_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid_o |-> ($stable(left_o) && $stable(right_o)));

    p_sticky_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err_o |=> fmt_err_o);

    p_no_pair_bad_combo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |-> combo_ok(frame_mode_i, width_sel_i));

    p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o && width_sel_i == WID_16) |-> (left_o[3:0] == 4'd0 && right_o[3:0] == 4'd0));

    p_zero_fill18_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o && width_sel_i == WID_18) |-> (left_o[1:0] == 2'd0 && right_o[1:0] == 2'd0));

endmodule

bind sar_rx sar_rx_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .width_sel_i  (width_sel_i),
    .frame_mode_i (frame_mode_i),
    .left_o       (left_o),
    .right_o      (right_o),
    .pair_valid_o (pair_valid_o),
    .fmt_err_o    (fmt_err_o)
);

// File: tb/sar_rx_tb_top.sv
module sar_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic [1:0]  wsel = 2'b00, fmode = 2'b11;
    logic        lhigh = 1'b1;
    logic [19:0] left_o, right_o;
    logic        pair_valid_o, fmt_err_o;

    always #4 clk = ~clk;

    sar_rx dut_i (
        .clk (clk), .rst_n (rst_n), .bclk_i (bclk), .lrclk_i (lrclk), .sdata_i (sdata),
        .width_sel_i (wsel), .frame_mode_i (fmode), .left_high_i (lhigh),
        .left_o (left_o), .right_o (right_o), .pair_valid_o (pair_valid_o), .fmt_err_o (fmt_err_o)
    );

    int    cyc = 0;
    int    checks = 0, errors = 0;
    bit    running = 0;
    bit    done = 0;
    string req = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    int          q_due[$];
    bit          q_pair[$];
    logic [19:0] q_l[$], q_r[$];

    bit          m_have, m_started, m_lr, m_err, m_lok;
    logic [19:0] m_lhold;
    bit          bits[$];

    function automatic int nbits(input logic [1:0] w);
        return (w == 2'b00) ? 16 : (w == 2'b01) ? 18 : 20;
    endfunction

    function automatic bit legal_cfg();
        if (fmode == 2'b01) return wsel == 2'b00;
        if (fmode == 2'b10) return wsel != 2'b11;
        return 1'b1;
    endfunction

    function automatic bit len_fits(input int len);
        case (fmode)
            2'b01: return len == 16;
            2'b10: return len == 24;
            2'b11: return len == 32;
            default: return (wsel == 2'b11) ? (len == 32) : (len >= nbits(wsel) && len <= 64);
        endcase
    endfunction

    task automatic push_evt(input int due, input bit pair, input logic [19:0] l, input logic [19:0] r);
        q_due.push_back(due); q_pair.push_back(pair); q_l.push_back(l); q_r.push_back(r);
    endtask

    task automatic eval_word(input int due);
        int          len = bits.size();
        logic [19:0] val = '0;
        int          n;
        if (len > 127) len = 127;
        if (wsel == 2'b11) begin
            for (int j = 1; j <= 20 && j < bits.size(); j++) val[20-j] = bits[j];
        end else begin
            n = nbits(wsel);
            for (int j = bits.size() - n; j < bits.size(); j++)
                if (j >= 0) val = {val[18:0], bits[j]};
            val = val << (20 - n);
        end
        if (!(legal_cfg() && len_fits(len))) begin
            push_evt(due, 1'b0, '0, '0);
            m_lok = 0;
        end else if (m_lr == lhigh) begin
            m_lhold = val; m_lok = 1;
        end else if (m_lok) begin
            push_evt(due, 1'b1, m_lhold, val);
            m_lok = 0;
        end
    endtask

    task automatic model_bit(input bit lvl, input bit b, input int due);
        if (!m_have) begin
            m_have = 1; m_lr = lvl; bits = {}; bits.push_back(b);
        end else if (lvl != m_lr) begin
            if (m_started) eval_word(due);
            m_started = 1; m_lr = lvl; bits = {}; bits.push_back(b);
        end else begin
            bits.push_back(b);
        end
    endtask

    task automatic send_bit(input bit lvl, input bit b);
        bclk = 1'b0; lrclk = lvl; sdata = b;
        repeat (2) @(posedge clk);
        #1;
        bclk = 1'b1;
        model_bit(lvl, b, cyc + 5);
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic send_period(input bit lvl, input int n);
        for (int i = 0; i < n; i++) send_bit(lvl, 1'($urandom % 2));
    endtask

    task automatic drain();
        repeat (12) @(posedge clk);
        #1;
    endtask

    task automatic run_pairs(input int np, input int ll, input int rl);
        send_period(!lhigh, 8);
        for (int i = 0; i < np; i++) begin
            send_period(lhigh, ll);
            send_period(!lhigh, rl);
        end
        send_period(lhigh, 4);
        drain();
    endtask

    task automatic do_reset(input logic [1:0] m, input logic [1:0] w, input bit pol, input string r);
        running = 0;
        rst_n = 1'b0;
        fmode = m; wsel = w; lhigh = pol;
        bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (left_o !== '0 || right_o !== '0 || pair_valid_o !== 1'b0 || fmt_err_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state actual=%h/%h/%b/%b expected=0/0/0/0",
                     left_o, right_o, pair_valid_o, fmt_err_o);
        end
        checks++;
        if (q_due.size() != 0) begin
            errors++;
            $display("FAIL R6 results still pending actual=%0d expected=0", q_due.size());
        end
        q_due = {}; q_pair = {}; q_l = {}; q_r = {};
        m_have = 0; m_started = 0; m_lr = 0; m_err = 0; m_lok = 0; m_lhold = '0; bits = {};
        req = r;
        rst_n = 1'b1;
        running = 1;
    endtask

    always @(negedge clk) begin
        bit          exp_v;
        logic [19:0] exp_l, exp_r;
        if (rst_n && running) begin
            exp_v = 0; exp_l = '0; exp_r = '0;
            while (q_due.size() > 0 && q_due[0] == cyc) begin
                if (q_pair[0]) begin exp_v = 1; exp_l = q_l[0]; exp_r = q_r[0]; end
                else m_err = 1;
                void'(q_due.pop_front()); void'(q_pair.pop_front());
                void'(q_l.pop_front()); void'(q_r.pop_front());
            end
            checks++;
            if (pair_valid_o !== exp_v || fmt_err_o !== m_err ||
                (exp_v && (left_o !== exp_l || right_o !== exp_r))) begin
                errors++;
                $display("FAIL %s cycle %0d actual v=%b e=%b L=%h R=%h expected v=%b e=%b L=%h R=%h",
                         req, cyc, pair_valid_o, fmt_err_o, left_o, right_o, exp_v, m_err, exp_l, exp_r);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R2 R3 R6 R7 R11: 16-bit right-justified, 64 clocks per frame
        do_reset(2'b11, 2'b00, 1'b1, "R2 R3 R6 R11");
        run_pairs(4, 32, 32);
        // R2: 18-bit
        do_reset(2'b11, 2'b01, 1'b1, "R2 R3");
        run_pairs(3, 32, 32);
        // R2 R5: 20-bit, left channel on low level
        do_reset(2'b11, 2'b10, 1'b0, "R2 R5");
        run_pairs(3, 32, 32);
        // R4: delayed-start format
        do_reset(2'b11, 2'b11, 1'b1, "R4");
        run_pairs(3, 32, 32);
        // R4 R5: delayed-start with inverted polarity
        do_reset(2'b11, 2'b11, 1'b0, "R4 R5");
        run_pairs(2, 32, 32);
        // R7: 32 and 48 clocks per frame
        do_reset(2'b01, 2'b00, 1'b1, "R7");
        run_pairs(3, 16, 16);
        do_reset(2'b10, 2'b10, 1'b1, "R7");
        run_pairs(3, 24, 24);
        // R8: free-running mode at its length limits
        do_reset(2'b00, 2'b00, 1'b1, "R8");
        run_pairs(2, 16, 64);
        do_reset(2'b00, 2'b10, 1'b0, "R8");
        run_pairs(2, 40, 20);
        // R8 R10: too-short word, then recovery with sticky flag
        do_reset(2'b00, 2'b10, 1'b1, "R8 R10");
        send_period(1'b0, 8);
        send_period(1'b1, 19);
        send_period(1'b0, 20);
        send_period(1'b1, 20);
        send_period(1'b0, 30);
        send_period(1'b1, 4);
        drain();
        // R9: illegal width for 32 clocks per frame
        do_reset(2'b01, 2'b01, 1'b1, "R9");
        run_pairs(2, 16, 16);
        do_reset(2'b10, 2'b11, 1'b1, "R9");
        run_pairs(2, 24, 24);
        // R7 R10: wrong length in a fixed mode cancels the pair
        do_reset(2'b11, 2'b00, 1'b1, "R7 R10");
        send_period(1'b0, 8);
        send_period(1'b1, 30);
        send_period(1'b0, 32);
        send_period(1'b1, 32);
        send_period(1'b0, 32);
        send_period(1'b1, 4);
        drain();
        do_reset(2'b11, 2'b00, 1'b1, "R1");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule